// File: doc/BRIEF.md
# Spaced Test Packet Generator

This block produces a stream of synthetic test packets for probing how a network path buffers and drops traffic. Software sets how many packets to send, how long each one is, how many clock ticks separate the start of one packet from the start of the next, and, optionally, how many packets form a back-to-back burst and how long the pause after each burst lasts. A start strobe launches a run. Packets leave on a byte-wide streaming port with valid, ready, first-byte and last-byte flags.

Each packet opens with a fixed eight-byte preamble. A 32-bit sequence number follows it, and a filler pattern fills the rest. The block counts the packets it sends. It also counts packets seen on a separate receive input, so a test can compare the two counts. The spacing timer counts clock ticks. At 200 MHz one tick is 5 ns.

Top module: `pkt_pacer`

## Requirements
- R1: After reset, `busy` and `tx_valid` are low and both `tx_count` and `rx_count` read zero.
- R2: A `start` pulse while idle with `cfg_pkts` non-zero makes `busy` high and presents the first byte (with `tx_sop`) in the next cycle. A `start` pulse with `cfg_pkts` zero does nothing, and so does a `start` pulse during a run.
- R3: Every packet is max(`cfg_bytes`, 12) bytes long. `tx_sop` marks byte 0 and `tx_eop` marks the last byte. Bytes 0 to 7 are 0xA5 XOR the byte index. Bytes 8 to 11 hold the sequence number, most significant byte first. Each later byte equals the low eight bits of its index.
- R4: The sequence number is 0 for the first packet of a run and goes up by one for each packet after it.
- R5: With `tx_ready` held high, the first byte of packet k+1 appears max(G, L) cycles after the first byte of packet k. Here L is the packet length and G is the gap in force. So a pitch of zero, or any pitch shorter than the packet, gives back-to-back packets.
- R6: When `cfg_burst_len` B is non-zero, the gap after packets B-1, 2B-1 and so on (counted from 0) is `cfg_burst_gap`. Every other gap is `cfg_pitch`. When B is zero, every gap is `cfg_pitch`.
- R7: While `tx_valid` is high and `tx_ready` is low, data, `tx_sop` and `tx_eop` hold their values into the next cycle.
- R8: A run sends exactly `cfg_pkts` packets. `busy` falls in the cycle after the last byte of the final packet is accepted.
- R9: A `stop` pulse during a packet ends the run once that packet completes. A `stop` pulse in a gap ends the run so that `busy` is low in the next cycle.
- R10: `tx_count` increments on every accepted last byte. `rx_count` increments in each cycle with both `rx_valid` and `rx_last` high. An accepted start clears both counters.
- R11: The configuration is captured when a run starts. Changing it during the run has no effect on that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one spacing tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_pkts | input | 32 | Packets per run |
| cfg_bytes | input | 16 | Packet length in bytes (minimum 12 enforced) |
| cfg_pitch | input | 32 | Start-to-start ticks inside a burst |
| cfg_burst_len | input | 16 | Packets per burst, 0 disables bursts |
| cfg_burst_gap | input | 32 | Start-to-start ticks after the last packet of a burst |
| start | input | 1 | Launch a run |
| stop | input | 1 | End the run after the current packet |
| busy | output | 1 | Run in progress |
| tx_ready | input | 1 | Downstream accepts a byte |
| tx_valid | output | 1 | Byte present |
| tx_data | output | 8 | Packet byte |
| tx_sop | output | 1 | First byte of packet |
| tx_eop | output | 1 | Last byte of packet |
| rx_valid | input | 1 | Receive side byte valid |
| rx_last | input | 1 | Receive side last byte of packet |
| tx_count | output | 32 | Packets sent this run |
| rx_count | output | 32 | Packets received since the last start |

## Verification
The bench goes after the pitch boundary, where the programmed gap is shorter than the packet or zero. A scheduler that waited for the gap alone would overlap packets or lose them, and one that added the gap after the packet end would space them too far apart. It checks that the long pause falls after every B-th packet. An off-by-one burst counter would shift every burst by one packet. It places a stop both inside a packet and in a gap. A design that cut the packet short or waited out the gap would show up in the packet count and the cycle in which busy falls. It also scrambles the configuration mid-run under random backpressure. A design that read the live inputs would send the wrong lengths or the wrong number of packets.

// File: rtl/pacer_pkg.sv
package pacer_pkg;
  localparam int SEQ_W     = 32;
  localparam int HDR_BYTES = 8;
  localparam int MIN_LEN   = HDR_BYTES + SEQ_W / 8;
  localparam logic [7:0] PRE_SEED = 8'hA5;

  typedef enum logic {RUN_IDLE, RUN_ACTIVE} run_e;

  // Byte at position idx of a packet carrying sequence number seq.
  function automatic logic [7:0] frame_byte(input logic [31:0] idx,
                                            input logic [SEQ_W-1:0] seq);
    logic [31:0] rel;
    logic [7:0]  b;
    rel = idx - 32'(HDR_BYTES);
    if (idx < 32'(HDR_BYTES)) begin
      b = PRE_SEED ^ idx[7:0];
    end else if (rel < 32'(SEQ_W / 8)) begin
      case (rel[1:0])
        2'd0:    b = seq[31:24];
        2'd1:    b = seq[23:16];
        2'd2:    b = seq[15:8];
        default: b = seq[7:0];
      endcase
    end else begin
      b = idx[7:0];
    end
    return b;
  endfunction
endpackage

// File: rtl/pacer_tally.sv
module pacer_tally #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = count;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = count + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= cnt_d;
  end

  // R10
  tally_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (count == $past(count) || count == $past(count) + W'(1)));
endmodule

// File: rtl/pacer_framer.sv
module pacer_framer
  import pacer_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic [LEN_W-1:0] launch_len,
  input  logic [SEQ_W-1:0] launch_seq,
  input  logic             tx_ready,
  output logic             tx_valid,
  output logic [7:0]       tx_data,
  output logic             tx_sop,
  output logic             tx_eop,
  output logic             active,
  output logic             done
);
  logic             act_q, act_d;
  logic [LEN_W-1:0] idx_q, idx_d, len_q, len_d;
  logic [SEQ_W-1:0] seq_q, seq_d;
  logic             at_end;

  assign at_end = (idx_q == len_q - LEN_W'(1));
  assign done   = act_q && tx_ready && at_end;
  assign active = act_q;

  always_comb begin
    act_d = act_q;
    idx_d = idx_q;
    len_d = len_q;
    seq_d = seq_q;
    if (launch) begin
      act_d = 1'b1;
      idx_d = '0;
      len_d = launch_len;
      seq_d = launch_seq;
    end else if (done) begin
      act_d = 1'b0;
    end else if (act_q && tx_ready) begin
      idx_d = idx_q + LEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      idx_q <= '0;
      len_q <= '0;
      seq_q <= '0;
    end else begin
      act_q <= act_d;
      idx_q <= idx_d;
      len_q <= len_d;
      seq_q <= seq_d;
    end
  end

  assign tx_valid = act_q;
  assign tx_sop   = act_q && (idx_q == '0);
  assign tx_eop   = act_q && at_end;
  assign tx_data  = frame_byte(32'(idx_q), seq_q);

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_sop) && $stable(tx_eop)));

  // R5
  eop_then_sop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_eop) |=> (!tx_valid || tx_sop));
endmodule

// File: rtl/pacer_sched.sv
module pacer_sched
  import pacer_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int CNT_W = 32,
  parameter int GAP_W = 32,
  parameter int BST_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic [CNT_W-1:0] cfg_pkts,
  input  logic [LEN_W-1:0] cfg_bytes,
  input  logic [GAP_W-1:0] cfg_pitch,
  input  logic [BST_W-1:0] cfg_burst_len,
  input  logic [GAP_W-1:0] cfg_burst_gap,
  input  logic             active,
  input  logic             done,
  output logic             launch,
  output logic [LEN_W-1:0] launch_len,
  output logic [SEQ_W-1:0] launch_seq,
  output logic             run_start,
  output logic             busy
);
  run_e             run_q, run_d;
  logic             stop_q, stop_d;
  logic [CNT_W-1:0] rem_q, rem_d;
  logic [GAP_W-1:0] since_q, since_d, tgt_q, tgt_d, pitch_q, pitch_d, bgap_q, bgap_d;
  logic [BST_W-1:0] bidx_q, bidx_d, blen_q, blen_d;
  logic [SEQ_W-1:0] seq_q, seq_d;
  logic [LEN_W-1:0] len_q, len_d, len_in;
  logic [GAP_W-1:0] since_nx;
  logic [BST_W-1:0] blen_use, cur_bidx;
  logic             running, stop_eff, free, gap_ok, more, last_in, finish;

  assign running   = (run_q == RUN_ACTIVE);
  assign len_in    = (cfg_bytes < LEN_W'(MIN_LEN)) ? LEN_W'(MIN_LEN) : cfg_bytes;
  assign run_start = !running && start && (cfg_pkts != '0);
  assign stop_eff  = stop_q || stop;
  assign free      = !active || done;
  assign since_nx  = (since_q == '1) ? since_q : since_q + GAP_W'(1);
  assign gap_ok    = (since_nx >= tgt_q);
  assign more      = running && !stop_eff && (rem_q != '0) && gap_ok && free;
  assign launch    = run_start || more;
  assign blen_use  = run_start ? cfg_burst_len : blen_q;
  assign cur_bidx  = run_start ? '0 : bidx_q;
  assign last_in   = (blen_use != '0) && (cur_bidx == blen_use - BST_W'(1));
  assign launch_len = run_start ? len_in : len_q;
  assign launch_seq = run_start ? '0 : seq_q;
  assign finish    = running && (stop_eff || rem_q == '0) && free;
  assign busy      = running;

  always_comb begin
    run_d   = run_q;
    stop_d  = stop_q;
    rem_d   = rem_q;
    since_d = since_nx;
    tgt_d   = tgt_q;
    bidx_d  = bidx_q;
    seq_d   = seq_q;
    len_d   = len_q;
    pitch_d = pitch_q;
    bgap_d  = bgap_q;
    blen_d  = blen_q;
    if (run_start) begin
      run_d   = RUN_ACTIVE;
      stop_d  = 1'b0;
      rem_d   = cfg_pkts - CNT_W'(1);
      len_d   = len_in;
      pitch_d = cfg_pitch;
      bgap_d  = cfg_burst_gap;
      blen_d  = cfg_burst_len;
    end else if (finish) begin
      run_d  = RUN_IDLE;
      stop_d = 1'b0;
    end else if (running && stop) begin
      stop_d = 1'b1;
    end
    if (launch) begin
      since_d = '0;
      if (last_in) tgt_d = run_start ? cfg_burst_gap : bgap_q;
      else         tgt_d = run_start ? cfg_pitch : pitch_q;
      bidx_d = last_in ? '0 : cur_bidx + BST_W'(1);
      seq_d  = launch_seq + SEQ_W'(1);
      if (!run_start) rem_d = rem_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= RUN_IDLE;
      stop_q  <= 1'b0;
      rem_q   <= '0;
      since_q <= '0;
      tgt_q   <= '0;
      bidx_q  <= '0;
      seq_q   <= '0;
      len_q   <= '0;
      pitch_q <= '0;
      bgap_q  <= '0;
      blen_q  <= '0;
    end else begin
      run_q   <= run_d;
      stop_q  <= stop_d;
      rem_q   <= rem_d;
      since_q <= since_d;
      tgt_q   <= tgt_d;
      bidx_q  <= bidx_d;
      seq_q   <= seq_d;
      len_q   <= len_d;
      pitch_q <= pitch_d;
      bgap_q  <= bgap_d;
      blen_q  <= blen_d;
    end
  end

  // R8
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(!active || done));

  // R11
  remaining_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running)) |-> (rem_q <= $past(rem_q)));
endmodule

// File: rtl/pkt_pacer.sv
module pkt_pacer
  import pacer_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int CNT_W = 32,
  parameter int GAP_W = 32,
  parameter int BST_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cfg_pkts,
  input  logic [LEN_W-1:0] cfg_bytes,
  input  logic [GAP_W-1:0] cfg_pitch,
  input  logic [BST_W-1:0] cfg_burst_len,
  input  logic [GAP_W-1:0] cfg_burst_gap,
  input  logic             start,
  input  logic             stop,
  output logic             busy,
  input  logic             tx_ready,
  output logic             tx_valid,
  output logic [7:0]       tx_data,
  output logic             tx_sop,
  output logic             tx_eop,
  input  logic             rx_valid,
  input  logic             rx_last,
  output logic [CNT_W-1:0] tx_count,
  output logic [CNT_W-1:0] rx_count
);
  logic [1:0]       rst_pipe;
  logic             rst_int_n;
  logic             launch, run_start, active, done;
  logic [LEN_W-1:0] launch_len;
  logic [SEQ_W-1:0] launch_seq;

  // Asserted at once, released after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  pacer_sched #(.LEN_W(LEN_W), .CNT_W(CNT_W), .GAP_W(GAP_W), .BST_W(BST_W)) u_sched (
    .clk(clk), .rst_n(rst_int_n), .start(start), .stop(stop),
    .cfg_pkts(cfg_pkts), .cfg_bytes(cfg_bytes), .cfg_pitch(cfg_pitch),
    .cfg_burst_len(cfg_burst_len), .cfg_burst_gap(cfg_burst_gap),
    .active(active), .done(done), .launch(launch), .launch_len(launch_len),
    .launch_seq(launch_seq), .run_start(run_start), .busy(busy)
  );

  pacer_framer #(.LEN_W(LEN_W)) u_framer (
    .clk(clk), .rst_n(rst_int_n), .launch(launch), .launch_len(launch_len),
    .launch_seq(launch_seq), .tx_ready(tx_ready), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_sop(tx_sop), .tx_eop(tx_eop),
    .active(active), .done(done)
  );

  pacer_tally #(.W(CNT_W)) u_tx_tally (
    .clk(clk), .rst_n(rst_int_n), .clr(run_start), .inc(done), .count(tx_count)
  );

  pacer_tally #(.W(CNT_W)) u_rx_tally (
    .clk(clk), .rst_n(rst_int_n), .clr(run_start), .inc(rx_valid && rx_last),
    .count(rx_count)
  );
endmodule

// File: tb/pkt_pacer_bench.sv
module pkt_pacer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_pkts = '0;
  logic [15:0] cfg_bytes = '0;
  logic [31:0] cfg_pitch = '0;
  logic [15:0] cfg_burst_len = '0;
  logic [31:0] cfg_burst_gap = '0;
  logic        start = 1'b0, stop = 1'b0, tx_ready = 1'b1;
  logic        rx_valid = 1'b0, rx_last = 1'b0;
  logic        busy, tx_valid, tx_sop, tx_eop;
  logic [7:0]  tx_data;
  logic [31:0] tx_count, rx_count;

  always #2 clk = ~clk;

  pkt_pacer u_pkt_pacer (
    .clk(clk), .rst_n(rst_n), .cfg_pkts(cfg_pkts), .cfg_bytes(cfg_bytes),
    .cfg_pitch(cfg_pitch), .cfg_burst_len(cfg_burst_len), .cfg_burst_gap(cfg_burst_gap),
    .start(start), .stop(stop), .busy(busy), .tx_ready(tx_ready), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_sop(tx_sop), .tx_eop(tx_eop), .rx_valid(rx_valid),
    .rx_last(rx_last), .tx_count(tx_count), .rx_count(rx_count)
  );

  int cyc = 0;
  int checks = 0, fails = 0;
  bit rdy_rand = 1'b0;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // ready is changed just after the active edge, never at the sampling edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      tx_ready = rdy_rand ? (($urandom % 3) != 0) : 1'b1;
    end
  end

  function automatic logic [7:0] exp_byte(int seq, int i);
    logic [31:0] s;
    s = seq;
    if (i < 8) return 8'hA5 ^ 8'(i);
    if (i < 12) return 8'(s >> (8 * (11 - i)));
    return 8'(i);
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // output monitor
  int npk, bi, exp_len, byte_err, stab_err, last_eop_cyc, busy_fall_cyc;
  int starts[64];
  bit prev_v, prev_r, prev_sop, prev_eop, prev_busy;
  logic [7:0] prev_d;

  initial begin
    npk = 0; bi = 0; exp_len = 12; byte_err = 0; stab_err = 0;
    last_eop_cyc = -1; busy_fall_cyc = -1;
    prev_v = 0; prev_r = 1; prev_sop = 0; prev_eop = 0; prev_busy = 0; prev_d = '0;
    forever begin
      @(negedge clk);
      if (prev_v && !prev_r) begin
        if (!tx_valid || tx_data !== prev_d || tx_sop !== prev_sop || tx_eop !== prev_eop)
          stab_err++;
      end
      if (tx_valid && tx_ready) begin
        if (tx_sop) begin
          if (npk < 64) starts[npk] = cyc;
          bi = 0;
        end
        if (tx_data !== exp_byte(npk, bi)) byte_err++;
        if (tx_eop) begin
          if (bi != exp_len - 1) byte_err++;
          last_eop_cyc = cyc;
          npk++;
        end else begin
          if (bi == exp_len - 1) byte_err++;
          bi++;
        end
      end
      if (prev_busy && !busy) busy_fall_cyc = cyc;
      prev_busy = busy; prev_v = tx_valid; prev_r = tx_ready;
      prev_d = tx_data; prev_sop = tx_sop; prev_eop = tx_eop;
    end
  end

  task automatic run_pkts(int n, int len, int sp, int bst, int idl, bit rr,
                          int stop_at, int exp_n, bit gap_stop, string tag);
    int c0, t_exp, bad, bad_k, g;
    @(negedge clk);
    cfg_pkts = n; cfg_bytes = 16'(len); cfg_pitch = sp;
    cfg_burst_len = 16'(bst); cfg_burst_gap = idl;
    rdy_rand = rr;
    npk = 0; byte_err = 0; stab_err = 0; busy_fall_cyc = -1; last_eop_cyc = -1;
    exp_len = imax(len, 12);
    start = 1'b1;
    c0 = cyc;
    @(negedge clk);
    start = 1'b0;
    // R11: scramble the configuration once the run is under way
    cfg_pkts = $urandom % 50 + 1; cfg_bytes = 16'($urandom % 200);
    cfg_pitch = $urandom % 30; cfg_burst_len = 16'($urandom % 3);
    cfg_burst_gap = $urandom % 30;
    chk(busy && tx_valid && tx_sop, "R2", {tag, " first byte after start"},
        {busy, tx_valid, tx_sop}, 3'b111);
    chk(tx_count == 0 && rx_count == 0, "R10", {tag, " counters cleared by start"},
        tx_count + rx_count, 0);
    for (int k = 0; k < 30000 && busy; k++) begin
      start = (k == 1);           // R2: start during a run is ignored
      stop = (k == stop_at);
      @(negedge clk);
    end
    start = 1'b0; stop = 1'b0;
    chk(!busy, "R8", {tag, " run ends"}, busy, 0);
    chk(npk == exp_n, "R8", {tag, " packets sent (R9/R11)"}, npk, exp_n);
    chk(byte_err == 0, "R3", {tag, " packet bytes and sequence numbers (R4)"}, byte_err, 0);
    chk(stab_err == 0, "R7", {tag, " hold under backpressure"}, stab_err, 0);
    chk(tx_count == exp_n, "R10", {tag, " tx_count"}, tx_count, exp_n);
    if (gap_stop)
      chk(busy_fall_cyc == c0 + 2 + stop_at, "R9", {tag, " busy fall after stop in gap"},
          busy_fall_cyc, c0 + 2 + stop_at);
    else
      chk(busy_fall_cyc == last_eop_cyc + 1, "R8", {tag, " busy fall cycle"},
          busy_fall_cyc, last_eop_cyc + 1);
    if (!rr) begin
      bad = 0; bad_k = 0;
      t_exp = c0 + 1;
      for (int k = 0; k < npk && k < 64; k++) begin
        if (k > 0) begin
          g = (bst > 0 && ((k - 1) % bst) == bst - 1) ? idl : sp;
          t_exp = t_exp + imax(g, exp_len);
        end
        if (starts[k] != t_exp && bad == 0) begin bad = 1; bad_k = k; end
      end
      chk(bad == 0, "R5", {tag, " packet start spacing (R6)"}, bad_k, 0);
    end
  endtask

  task automatic rx_burst(int cycles);
    int exp_rx;
    exp_rx = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      rx_valid = $urandom % 2;
      rx_last = $urandom % 2;
      if (rx_valid && rx_last) exp_rx++;
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0;
    @(negedge clk);
    chk(rx_count == exp_rx, "R10", "rx_count counts valid last bytes only", rx_count, exp_rx);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog run did not complete actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int saved;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    chk(!busy && !tx_valid, "R1", "idle after reset", {busy, tx_valid}, 0);
    chk(tx_count == 0 && rx_count == 0, "R1", "counters zero after reset",
        tx_count + rx_count, 0);

    // directed: spacing longer than the packet
    run_pkts(5, 20, 40, 0, 0, 0, -1, 5, 0, "pitch40");
    // directed: pitch zero gives back-to-back, short length clamped to 12
    run_pkts(4, 3, 0, 0, 0, 0, -1, 4, 0, "pitch0");
    // directed: pitch shorter than the packet
    run_pkts(3, 30, 10, 0, 0, 0, -1, 3, 0, "pitch_short");
    // directed: bursts of four with a long pause (R6)
    run_pkts(10, 16, 20, 4, 200, 0, -1, 10, 0, "burst4");
    // directed: burst length one uses the pause after every packet (R6)
    run_pkts(3, 12, 50, 1, 70, 0, -1, 3, 0, "burst1");
    // directed: jumbo packets back to back
    run_pkts(2, 9000, 0, 0, 0, 0, -1, 2, 0, "jumbo");
    // R9: stop inside the second packet
    run_pkts(10, 20, 40, 0, 0, 0, 45, 2, 0, "stop_in_pkt");
    // R9: stop in the gap after the first packet
    run_pkts(10, 12, 40, 0, 0, 0, 20, 1, 1, "stop_in_gap");

    rx_burst(40);

    // R2: start with zero packets does nothing
    saved = tx_count;
    @(negedge clk);
    cfg_pkts = 0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !tx_valid && tx_count == saved, "R2", "start with zero packets ignored",
        {busy, tx_valid}, 0);

    // constrained random runs, some under backpressure
    for (int r = 0; r < 8; r++) begin
      int n, len, sp, bst, idl;
      bit rr;
      n = $urandom % 12 + 1; len = $urandom % 41; sp = $urandom % 61;
      bst = $urandom % 5; idl = $urandom % 101; rr = $urandom % 2;
      run_pkts(n, len, sp, bst, idl, rr, -1, n, 0, $sformatf("rand%0d", r));
    end
    rx_burst(25);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule